// File: doc/BRIEF.md
# Two-Wire Serial Byte and Status Register Unit

This block is the CPU-facing register front end of a two-wire serial controller. It holds one byte register that serves both directions: on every shift strobe the register's top bit is driven onto the serial line and the sampled line bit enters at the bottom. After eight strobes the register therefore holds whatever byte actually appeared on the wire, whether the controller was sending or receiving. The CPU may load a new byte only while the interrupt flag is raised, which is the window in which no shifting takes place.

The block also composes a read-only status word. The upper five bits are a code captured from the bus state logic, one bit is fixed at zero, and the bottom two bits are a CPU-writable prescaler select. The prescaler select is decoded into a one-hot divide value for the bit-rate counter. An interrupt flag is raised by a byte-complete pulse and lowered by a CPU clear strobe. The interrupt request is driven whenever that flag, a local enable and a global enable are all high.

Top module: `sbr_top`

## Requirements
- R1: While reset is asserted and just after it is released, address 0 reads 0xFF, address 1 reads 0xF8 (status code all ones, prescaler 00), and `int_flag` and `irq` are low.
- R2: Address 1 reads {captured status code in bits 7:3, 0 in bit 2, prescaler select in bits 1:0}. The status code is the `bus_status` value captured at the previous clock edge. A write to address 1 changes only bits 1:0, and bit 2 reads zero even when it is written as one.
- R3: `presc_div` decodes the prescaler select as 00→1, 01→4, 10→16, 11→64.
- R4: On a `shift_en` cycle with the flag low, the data register shifts left by one and `sda_in` enters bit 0. After eight such shifts it holds the eight sampled bits, with the first one sampled in the MSB.
- R5: `sda_out` always equals bit 7 of the data register.
- R6: A write to address 0 while `int_flag` is high loads `cpu_wdata` into the data register at that edge.
- R7: A write to address 0 while `int_flag` is low is ignored. If `shift_en` is high in the same cycle, the shift still takes place.
- R8: While `int_flag` is high, `shift_en` has no effect on the data register.
- R9: `byte_done` sets `int_flag` at the next edge and `flag_clr` clears it. When both are high in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when `int_flag`, `int_en` and `glob_int_en` are all high.
- R11: Reading either address (selecting it with `cpu_wr` low) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 1 | Register select: 0 data byte, 1 status word |
| cpu_wr | input | 1 | Write strobe for the selected register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| bus_status | input | 5 | Status code from the bus state logic |
| shift_en | input | 1 | One-bit shift strobe |
| sda_in | input | 1 | Sampled serial line bit |
| byte_done | input | 1 | One-cycle byte-complete pulse |
| flag_clr | input | 1 | CPU strobe that clears the interrupt flag |
| int_en | input | 1 | Local interrupt enable |
| glob_int_en | input | 1 | Global interrupt enable |
| sda_out | output | 1 | Serial bit to drive onto the line |
| int_flag | output | 1 | Interrupt flag |
| irq | output | 1 | Interrupt request |
| presc_div | output | 7 | One-hot prescaler divide value |

## Verification
Two pairs of events can land on the same edge. The first is a byte-complete pulse together with a CPU flag clear. The bench raises both in one cycle and expects the flag to remain set, then clears it alone and expects it to drop. The second is a CPU data write together with a shift strobe while the flag is low. The bench expects the shifted value, not the written byte, and checks it through the data read port and `sda_out`.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  parameter int DATA_W = 8;
  parameter int STAT_W = 5;
  parameter int PS_W   = 2;
  localparam int RSV_W = DATA_W - STAT_W - PS_W;
  localparam int DIV_W = 2 * ((1 << PS_W) - 1) + 1;

  typedef enum logic {
    ADDR_DATA = 1'b0,
    ADDR_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/sbr_rst_sync.sv
module sbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sbr_shift_reg.sv
module sbr_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flag_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         shift_i,
  input  logic         sdi_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] d_q, d_nxt;
  logic         d_en;

  always_comb begin
    d_nxt = d_q;
    d_en  = 1'b0;
    if (flag_i) begin
      if (wr_i) begin
        d_nxt = wdata_i;
        d_en  = 1'b1;
      end
    end else if (shift_i) begin
      d_nxt = {d_q[W-2:0], sdi_i};
      d_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    d_q <= '1;
    else if (d_en) d_q <= d_nxt;
  end

  assign data_o = d_q;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !flag_i) |=> (d_q == {$past(d_q[W-2:0]), $past(sdi_i)})); // R4
  AST_LOAD_IN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && flag_i) |=> (d_q == $past(wdata_i))); // R6
  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !flag_i && !shift_i) |=> $stable(d_q)); // R7
  AST_HOLD_IN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i && !wr_i) |=> $stable(d_q)); // R8
endmodule

// File: rtl/sbr_status_reg.sv
module sbr_status_reg
  import sbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_i,
  input  logic              wr_i,
  input  logic [PS_W-1:0]   ps_wdata_i,
  output logic [DATA_W-1:0] word_o,
  output logic [DIV_W-1:0]  div_o
);
  logic [STAT_W-1:0] stat_q;
  logic [PS_W-1:0]   ps_q, ps_nxt;
  logic              ps_en;

  always_comb begin
    ps_en  = wr_i;
    ps_nxt = ps_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '1;
      ps_q   <= '0;
    end else begin
      stat_q <= status_i;
      if (ps_en) ps_q <= ps_nxt;
    end
  end

  assign word_o = {stat_q, {RSV_W{1'b0}}, ps_q};

  for (genvar j = 0; j < DIV_W; j++) begin : g_div
    if (j % 2 == 0) begin : g_even
      assign div_o[j] = (ps_q == PS_W'(j / 2));
    end else begin : g_odd
      assign div_o[j] = 1'b0;
    end
  end

  AST_DIV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(div_o) == 1); // R3
  AST_PS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(word_o[PS_W-1:0])); // R11
  AST_STAT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (word_o[DATA_W-1 -: STAT_W] == $past(status_i))); // R2
endmodule

// File: rtl/sbr_irq.sv
module sbr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic clr_i,
  input  logic ie_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_nxt;

  always_comb begin
    flag_nxt = flag_q;
    if (done_i)     flag_nxt = 1'b1;
    else if (clr_i) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_nxt;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i & gie_i;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> flag_q); // R9
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !done_i) |=> !flag_q); // R9
endmodule

// File: rtl/sbr_top.sv
module sbr_top
  import sbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [STAT_W-1:0] bus_status,
  input  logic              shift_en,
  input  logic              sda_in,
  input  logic              byte_done,
  input  logic              flag_clr,
  input  logic              int_en,
  input  logic              glob_int_en,
  output logic              sda_out,
  output logic              int_flag,
  output logic              irq,
  output logic [DIV_W-1:0]  presc_div
);
  logic              rst_i_n;
  logic              wr_data, wr_stat;
  logic [DATA_W-1:0] data_w, stat_w;

  sbr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign wr_data = cpu_wr && (reg_sel_e'(cpu_addr) == ADDR_DATA);
  assign wr_stat = cpu_wr && (reg_sel_e'(cpu_addr) == ADDR_STAT);

  sbr_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .done_i (byte_done),
    .clr_i  (flag_clr),
    .ie_i   (int_en),
    .gie_i  (glob_int_en),
    .flag_o (int_flag),
    .irq_o  (irq)
  );

  sbr_shift_reg #(.W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .flag_i  (int_flag),
    .wr_i    (wr_data),
    .wdata_i (cpu_wdata),
    .shift_i (shift_en),
    .sdi_i   (sda_in),
    .data_o  (data_w)
  );

  sbr_status_reg u_stat (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .status_i   (bus_status),
    .wr_i       (wr_stat),
    .ps_wdata_i (cpu_wdata[PS_W-1:0]),
    .word_o     (stat_w),
    .div_o      (presc_div)
  );

  assign cpu_rdata = (reg_sel_e'(cpu_addr) == ADDR_STAT) ? stat_w : data_w;
  assign sda_out   = data_w[DATA_W-1];

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    cpu_addr |-> (cpu_rdata[PS_W] == 1'b0)); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> (int_flag && int_en && glob_int_en)); // R10
  AST_SDO_TRACKS: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cpu_addr |-> (sda_out == cpu_rdata[DATA_W-1])); // R5
endmodule

// File: tb/sbr_top_bench.sv
`timescale 1ns/1ps
module sbr_top_bench;
  localparam time TCK = 8ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_addr, cpu_wr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic [4:0] bus_status;
  logic       shift_en, sda_in, byte_done, flag_clr, int_en, glob_int_en;
  logic       sda_out, int_flag, irq;
  logic [6:0] presc_div;

  always #(TCK/2) clk = ~clk;

  sbr_top u_sbr_top (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bus_status(bus_status),
    .shift_en(shift_en), .sda_in(sda_in), .byte_done(byte_done),
    .flag_clr(flag_clr), .int_en(int_en), .glob_int_en(glob_int_en),
    .sda_out(sda_out), .int_flag(int_flag), .irq(irq), .presc_div(presc_div)
  );

  typedef struct {
    string      tag;
    int         sel;   // 0 rdata, 1 sda_out, 2 int_flag, 3 irq, 4 presc_div
    logic [7:0] exp;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [7:0] md;  // bench model of the data byte

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return cpu_rdata;
      1: return {7'd0, sda_out};
      2: return {7'd0, int_flag};
      3: return {7'd0, irq};
      default: return {1'b0, presc_div};
    endcase
  endfunction

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = observe(it.sel);
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h (sel %0d)", it.tag, act, it.exp, it.sel);
      end
    end
  end

  task automatic push(string tag, int sel, logic [7:0] exp);
    sb_item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic shift_byte(input logic [7:0] b, input bit also_wr, input string tag);
    for (int i = 7; i >= 0; i--) begin
      cpu_addr = 1'b0;
      push("R5", 1, {7'd0, md[7]});
      shift_en = 1'b1; sda_in = b[i];
      if (also_wr) begin cpu_wr = 1'b1; cpu_wdata = 8'h5A; end
      cyc();
      shift_en = 1'b0; cpu_wr = 1'b0;
      md = {md[6:0], b[i]};
    end
    push(tag, 0, md);
  endtask

  task automatic pulse_done(bit with_clr);
    byte_done = 1'b1; flag_clr = with_clr;
    cyc();
    byte_done = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
  endtask

  initial begin
    #(200000 * TCK);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = 1'b0; cpu_wr = 1'b0; cpu_wdata = 8'h00;
    bus_status = 5'h1F; shift_en = 1'b0; sda_in = 1'b0; byte_done = 1'b0;
    flag_clr = 1'b0; int_en = 1'b1; glob_int_en = 1'b1;
    repeat (3) cyc();
    // R1 reset values during reset
    push("R1", 0, 8'hFF); push("R1", 2, 8'h00); push("R1", 3, 8'h00);
    cyc();
    cpu_addr = 1'b1; push("R1", 0, 8'hF8); push("R3", 4, 8'h01);
    cyc();
    rst_n = 1'b1;
    repeat (3) cyc();
    cpu_addr = 1'b0; push("R1", 0, 8'hFF);
    cyc();
    cpu_addr = 1'b1; push("R1", 0, 8'hF8);
    cyc();
    md = 8'hFF;

    // R4/R5: receive-style shift of 0xA5
    shift_byte(8'hA5, 1'b0, "R4");
    cyc();
    // R11: repeated reads leave the value intact
    cpu_addr = 1'b1; cyc(); cpu_addr = 1'b0; cyc();
    push("R11", 0, 8'hA5);
    cyc();

    // R9/R10: flag set, irq gating
    pulse_done(1'b0);
    push("R9", 2, 8'h01); push("R10", 3, 8'h01);
    cyc();
    int_en = 1'b0; #1; push("R10", 3, 8'h00); cyc();
    int_en = 1'b1; glob_int_en = 1'b0; #1; push("R10", 3, 8'h00); cyc();
    glob_int_en = 1'b1; #1; push("R10", 3, 8'h01); cyc();

    // R8: shift ignored while flag set
    shift_en = 1'b1; sda_in = 1'b0; cyc(); cyc(); shift_en = 1'b0;
    cpu_addr = 1'b0; push("R8", 0, 8'hA5); push("R5", 1, 8'h01);
    cyc();

    // R6: write accepted while flag set
    cpu_addr = 1'b0; cpu_wr = 1'b1; cpu_wdata = 8'h3C; cyc(); cpu_wr = 1'b0;
    md = 8'h3C; push("R6", 0, 8'h3C); push("R5", 1, 8'h00);
    cyc();

    // R9: clear alone
    clear_flag();
    push("R9", 2, 8'h00); push("R10", 3, 8'h00);
    cyc();

    // R7: write ignored while flag low
    cpu_wr = 1'b1; cpu_wdata = 8'h11; cyc(); cpu_wr = 1'b0;
    push("R7", 0, 8'h3C);
    cyc();

    // R7 concurrency: write plus shift with flag low, shift wins
    shift_byte(8'h96, 1'b1, "R7");
    cyc();

    // R9 concurrency: done and clear in the same cycle
    pulse_done(1'b1);
    push("R9", 2, 8'h01);
    cyc();
    clear_flag();
    push("R9", 2, 8'h00);
    cyc();

    // R2/R3: prescaler writes with upper bits set
    for (int v = 0; v < 4; v++) begin
      cpu_addr = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'hFC | 8'(v);
      cyc();
      cpu_wr = 1'b0;
      push("R2", 0, {5'h1F, 1'b0, 2'(v)});
      push("R3", 4, 8'(1 << (2 * v)));
      cyc();
    end

    // R2: status code captured one edge after it changes
    bus_status = 5'h0A; cpu_addr = 1'b1;
    push("R2", 0, {5'h1F, 1'b0, 2'b11});
    cyc();
    push("R2", 0, {5'h0A, 1'b0, 2'b11});
    cyc();
    push("R11", 4, 8'h40);
    cpu_addr = 1'b0; push("R11", 0, md);
    cyc(); cyc();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule